// File: doc/BRIEF.md
# Multi-Channel Alarm Interrupt Controller

This block gathers alarm conditions for eight line channels from three alarm kinds: loss of signal, driver failure and alarm indication signal. Each kind has a status register with one bit per channel. The register follows the detector input it is fed from. Whenever a status bit changes, whether it sets or clears, a change flag for that channel and kind is latched.

The host reaches the block through a plain single-cycle register port. It can read the status, flag and enable registers, write the enable masks, and clear flags by writing ones. An active-low interrupt line is pulled low while any flag whose enable bit is set is pending. The line goes high again only once every enabled flag in all three kinds has been cleared.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset every status, flag and enable register reads 0x00 and `irq_n_o` is high.
- R2: Status registers can be read at fixed addresses: loss of signal at 0x04, driver failure at 0x05, alarm indication at 0x13. Bit i is channel i. Each register shows the input value sampled on the previous clock edge, so a change at the input can be read after one edge.
- R3: When a status bit goes from 0 to 1, the matching flag bit is set on the next edge. The flag can therefore be read two edges after the input changed.
- R4: When a status bit goes from 1 to 0, the matching flag bit is set in the same way.
- R5: Flags can be read at 0x08 (loss of signal), 0x09 (driver failure) and 0x0A (alarm indication). Writing 1 to a flag bit clears it. Writing 0 leaves the bit as it is.
- R6: When a change and a write-1 clear reach the same flag bit on the same edge, the flag stays set.
- R7: Enable masks can be read and written at 0x0C (loss of signal), 0x0D (driver failure) and 0x0E (alarm indication). `irq_n_o` is low exactly when some flag bit and its enable bit are both 1.
- R8: A flag whose enable bit is 0 still latches changes but does not pull `irq_n_o` low.
- R9: `irq_n_o` stays low until the last enabled flag bit in all three kinds has been cleared.
- R10: Writes to the status addresses have no effect on status. Reads from addresses that are not mapped return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| los_alarm_i | input | 8 | Loss-of-signal detector outputs, one per channel |
| dfm_alarm_i | input | 8 | Driver-failure detector outputs, one per channel |
| ais_alarm_i | input | 8 | Alarm-indication detector outputs, one per channel |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Two functions can act on the same flag bit in one cycle: a detected status change sets it and a host write-1 clears it. To provoke this, the bench toggles a channel input one cycle before the edge on which it writes the clear. The change then reaches the flag register on the same edge as the clear. The flag is read back right after that edge and must still be set. A second clear on a quiet cycle must then remove it. The bench also checks that the interrupt line stays low while an enabled flag of another alarm kind is still pending, even though one kind has just been cleared.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the alarm interrupt controller.
// Assumes three alarm kinds and a 5-bit register address space.
package alarm_irq_pkg;
    localparam int NSRC = 3;
    localparam int AW   = 5;

    typedef enum logic [1:0] {
        SRC_LOS = 2'd0,
        SRC_DFM = 2'd1,
        SRC_AIS = 2'd2
    } alarm_src_e;

    localparam logic [AW-1:0] FLAG_BASE = 5'h08;
    localparam logic [AW-1:0] EN_BASE   = 5'h0C;

    // Fixed status address per alarm kind.
    function automatic logic [AW-1:0] stat_addr(input int s);
        case (s)
            0:       return 5'h04;
            1:       return 5'h05;
            default: return 5'h13;
        endcase
    endfunction

    function automatic logic [AW-1:0] flag_addr(input int s);
        return FLAG_BASE + AW'(s);
    endfunction

    function automatic logic [AW-1:0] en_addr(input int s);
        return EN_BASE + AW'(s);
    endfunction
endpackage

// File: rtl/alarm_src_track.sv
`timescale 1ns/1ps
// Per-kind tracker: samples the raw detector vector into a status register,
// remembers the previous status, latches per-channel change flags (set has
// priority over write-1 clear) and holds the enable mask.
// Assumes the raw inputs are synchronous to clk.
module alarm_src_track #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_i,
    input  logic           clr_we_i,
    input  logic           en_we_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] status_o,
    output logic [NCH-1:0] flag_o,
    output logic [NCH-1:0] enable_o
);
    logic [NCH-1:0] stat_q, prev_q, flag_q, en_q;
    logic [NCH-1:0] chg, clr_mask;

    // Bits that differ between current and previous status.
    always_comb begin
        chg      = stat_q ^ prev_q;
        clr_mask = clr_we_i ? wdata_i : '0;
    end

    // Sample detector vector and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            stat_q <= raw_i;
            prev_q <= stat_q;
        end
    end

    // Latch change flags; a new change overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | chg;
    end

    // Host-written enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= wdata_i;
    end

    assign status_o = stat_q;
    assign flag_o   = flag_q;
    assign enable_o = en_q;
endmodule

// File: rtl/alarm_reg_decode.sv
`timescale 1ns/1ps
// Register decoder: turns the address and write strobe into per-kind clear
// and enable strobes, and multiplexes read data. Status addresses are read-only.
// Assumes a single-cycle write and combinational read.
module alarm_reg_decode
    import alarm_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [AW-1:0]       addr_i,
    input  logic                wr_i,
    input  logic [NSRC*NCH-1:0] stat_all_i,
    input  logic [NSRC*NCH-1:0] flag_all_i,
    input  logic [NSRC*NCH-1:0] en_all_i,
    output logic [NSRC-1:0]     clr_we_o,
    output logic [NSRC-1:0]     en_we_o,
    output logic [NCH-1:0]      rdata_o
);
    // Per-kind write strobes.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            clr_we_o[s] = wr_i && (addr_i == flag_addr(s));
            en_we_o[s]  = wr_i && (addr_i == en_addr(s));
        end
    end

    // Read multiplexer; unmapped addresses give zero.
    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (addr_i == stat_addr(s)) rdata_o = stat_all_i[s*NCH +: NCH];
            if (addr_i == flag_addr(s)) rdata_o = flag_all_i[s*NCH +: NCH];
            if (addr_i == en_addr(s))   rdata_o = en_all_i[s*NCH +: NCH];
        end
    end
endmodule

// File: rtl/alarm_irq_merge.sv
`timescale 1ns/1ps
// Interrupt merge: drives the active-low request while any flag bit is
// pending with its enable set, in any of the alarm kinds.
module alarm_irq_merge #(
    parameter int W = 24
) (
    input  logic [W-1:0] flag_i,
    input  logic [W-1:0] en_i,
    output logic         irq_n_o
);
    // Low while any enabled flag is pending.
    always_comb irq_n_o = ~(|(flag_i & en_i));
endmodule

// File: rtl/alarm_irq_ctrl.sv
`timescale 1ns/1ps
// Top of the alarm interrupt controller: one tracker per alarm kind, a
// register decoder and the interrupt merge. Kind index 0 is loss of signal,
// 1 driver failure, 2 alarm indication.
// Assumes detector inputs and host port are synchronous to clk.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] los_alarm_i,
    input  logic [NCH-1:0] dfm_alarm_i,
    input  logic [NCH-1:0] ais_alarm_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic           reg_wr_i,
    input  logic [NCH-1:0] reg_wdata_i,
    output logic [NCH-1:0] reg_rdata_o,
    output logic           irq_n_o
);
    localparam int TOTW = NSRC * NCH;

    logic [TOTW-1:0] raw_all, stat_all, flag_all, en_all;
    logic [NSRC-1:0] clr_we, en_we;

    assign raw_all = {ais_alarm_i, dfm_alarm_i, los_alarm_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        alarm_src_track #(.NCH(NCH)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (raw_all[s*NCH +: NCH]),
            .clr_we_i (clr_we[s]),
            .en_we_i  (en_we[s]),
            .wdata_i  (reg_wdata_i),
            .status_o (stat_all[s*NCH +: NCH]),
            .flag_o   (flag_all[s*NCH +: NCH]),
            .enable_o (en_all[s*NCH +: NCH])
        );
    end

    alarm_reg_decode #(.NCH(NCH)) u_dec (
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .stat_all_i (stat_all),
        .flag_all_i (flag_all),
        .en_all_i   (en_all),
        .clr_we_o   (clr_we),
        .en_we_o    (en_we),
        .rdata_o    (reg_rdata_o)
    );

    alarm_irq_merge #(.W(TOTW)) u_merge (
        .flag_i  (flag_all),
        .en_i    (en_all),
        .irq_n_o (irq_n_o)
    );
endmodule

// File: rtl/alarm_irq_chk.sv
`timescale 1ns/1ps
// Assertion checker for alarm_irq_ctrl, attached by bind. It keeps its own
// copy of the previous status to judge change detection independently.
module alarm_irq_chk
    import alarm_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       reg_addr_i,
    input logic                reg_wr_i,
    input logic [NCH-1:0]      reg_wdata_i,
    input logic [NSRC*NCH-1:0] raw_all,
    input logic [NSRC*NCH-1:0] stat_all,
    input logic [NSRC*NCH-1:0] flag_all,
    input logic [NSRC*NCH-1:0] en_all,
    input logic                irq_n_o
);
    logic [NSRC*NCH-1:0] stat_seen;
    logic [NSRC*NCH-1:0] chg_obs;

    // Checker-side history of the status vector.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_seen <= '0;
        else        stat_seen <= stat_all;
    end
    assign chg_obs = stat_all ^ stat_seen;

    // R2: status equals the input sampled on the previous edge.
    p_status_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_all == $past(raw_all)));

    // R3, R4, R6: every observed change lands in the flag, even with a clear.
    p_change_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_obs) |=> ((flag_all & $past(chg_obs)) == $past(chg_obs)));

    // R5: a flag bit only rises because of a change.
    p_flag_needs_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_all & ~$past(flag_all) & ~$past(chg_obs)) == '0));

    // R5: write-1 to the loss-of-signal flags clears bits not changing.
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == FLAG_BASE) |=>
        ((flag_all[NCH-1:0] & $past(reg_wdata_i & ~chg_obs[NCH-1:0])) == '0));

    // R9: interrupt released only with no enabled flag left.
    p_irq_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n_o) |-> ((flag_all & en_all) == '0));

    // R7: interrupt asserted only with some enabled flag pending.
    p_irq_assert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> (|(flag_all & en_all)));
endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .raw_all     (raw_all),
    .stat_all    (stat_all),
    .flag_all    (flag_all),
    .en_all      (en_all),
    .irq_n_o     (irq_n_o)
);

// File: tb/tb_alarm_irq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected reads into a queue and the
// monitor pops and compares them against the design's outputs.
module tb_alarm_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] los = '0, dfm = '0, ais = '0;
    logic [4:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    alarm_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .los_alarm_i(los), .dfm_alarm_i(dfm), .ais_alarm_i(ais),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_n_o(irq_n)
    );

    // Monitor: pops each expectation and compares it with the live output.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            #0.2;
            begin
                exp_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq_n} : rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_reg(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #0.1;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        exp_t it;
        it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #0.1;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step(1);
        wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        exp_reg(5'h04, 8'h00, "R1 los status");
        exp_reg(5'h05, 8'h00, "R1 dfm status");
        exp_reg(5'h13, 8'h00, "R1 ais status");
        exp_reg(5'h08, 8'h00, "R1 los flag");
        exp_reg(5'h09, 8'h00, "R1 dfm flag");
        exp_reg(5'h0A, 8'h00, "R1 ais flag");
        exp_reg(5'h0C, 8'h00, "R1 los en");
        exp_reg(5'h0D, 8'h00, "R1 dfm en");
        exp_reg(5'h0E, 8'h00, "R1 ais en");
        exp_irq(1'b1, "R1 irq idle");

        wr_reg(5'h0C, 8'hFF);
        wr_reg(5'h0D, 8'h0F);
        wr_reg(5'h0E, 8'hFF);
        exp_reg(5'h0D, 8'h0F, "R7 enable readback");

        // R2/R3: rising change latency
        los = 8'h05;
        exp_reg(5'h04, 8'h00, "R2 status before edge");
        step(1);
        exp_reg(5'h04, 8'h05, "R2 status after one edge");
        exp_reg(5'h08, 8'h00, "R3 flag not yet");
        exp_irq(1'b1, "R3 irq not yet");
        step(1);
        exp_reg(5'h08, 8'h05, "R3 flag set on rise");
        exp_irq(1'b0, "R7 irq asserted");

        // R5: write-1 clear, zeros untouched
        wr_reg(5'h08, 8'h01);
        exp_reg(5'h08, 8'h04, "R5 partial clear");
        exp_irq(1'b0, "R9 irq held by remaining bit");
        wr_reg(5'h08, 8'h04);
        exp_reg(5'h08, 8'h00, "R5 full clear");
        exp_irq(1'b1, "R9 irq released");

        // R4: falling change
        los = 8'h00;
        step(2);
        exp_reg(5'h08, 8'h05, "R4 flag set on fall");
        exp_reg(5'h04, 8'h00, "R4 status cleared");
        wr_reg(5'h08, 8'hFF);
        exp_reg(5'h08, 8'h00, "R5 clear all");

        // R6: change and clear on the same edge
        los = 8'h01;
        step(2);
        exp_reg(5'h08, 8'h01, "R6 setup flag");
        los = 8'h00;
        step(1);
        wr_reg(5'h08, 8'h01);
        exp_reg(5'h08, 8'h01, "R6 change beats clear");
        wr_reg(5'h08, 8'h01);
        exp_reg(5'h08, 8'h00, "R6 quiet clear works");
        exp_irq(1'b1, "R6 irq idle");

        // R8: disabled bits latch but do not interrupt
        dfm = 8'h30;
        step(2);
        exp_reg(5'h09, 8'h30, "R8 disabled flag latched");
        exp_irq(1'b1, "R8 irq stays high");
        dfm = 8'h31;
        step(2);
        exp_reg(5'h09, 8'h31, "R8 enabled bit adds");
        exp_irq(1'b0, "R7 irq from dfm bit0");

        // R9: release only after all kinds are clear
        ais = 8'h80;
        step(2);
        exp_reg(5'h13, 8'h80, "R2 ais status");
        wr_reg(5'h09, 8'hFF);
        exp_reg(5'h09, 8'h00, "R5 dfm clear");
        exp_irq(1'b0, "R9 ais still pending");
        wr_reg(5'h0A, 8'h80);
        exp_irq(1'b1, "R9 released after last");

        // R7: masking a pending flag
        ais = 8'h00;
        step(2);
        exp_irq(1'b0, "R7 ais fall asserts");
        wr_reg(5'h0E, 8'h00);
        exp_irq(1'b1, "R7 mask hides flag");
        exp_reg(5'h0A, 8'h80, "R8 flag kept while masked");
        wr_reg(5'h0E, 8'hFF);
        exp_irq(1'b0, "R7 unmask reasserts");
        wr_reg(5'h0A, 8'hFF);
        exp_irq(1'b1, "R9 clean");

        // R10: status read-only, unmapped reads zero
        los = 8'h22;
        step(1);
        wr_reg(5'h04, 8'hFF);
        exp_reg(5'h04, 8'h22, "R10 los status unaffected");
        wr_reg(5'h13, 8'h5A);
        exp_reg(5'h13, 8'h00, "R10 ais status unaffected");
        exp_reg(5'h1F, 8'h00, "R10 unmapped read");
        exp_reg(5'h0B, 8'h00, "R10 gap read");

        step(2);
        wait (sb_q.size() == 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule